// File: doc/BRIEF.md
# Pipelined ADC Redundant-Code Correction

This block turns the per-stage codes of a pipelined analog-to-digital converter into one binary result word. Each accepted input beat carries one 2-bit code from each of six 1.5-bit stages and from a closing 2-bit flash stage. Because the converter is pipelined, the first stage's code for a sample arrives six beats before the flash stage's code for that same sample. Each later stage arrives one beat closer.

Each stage lane is held in a delay line so that all seven codes of one sample meet in the same beat. The aligned codes are then summed. Each code is weighted so that the low bit of a more significant stage lands on the high bit of the stage below it. The sum is registered and offered on a valid/ready output.

Input and output use valid/ready handshakes. A beat transfers on a clock edge where valid and ready are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, no input is taken, the output word is held, and every delay line stays still. Delays are counted in accepted beats, not in clock cycles.

Top module: `adc_corr_top`

## Requirements
- R1: While reset is high at a clock edge, the block clears all delay lines, the fill count and the error flag, and drives `out_valid` low. After that edge `out_valid` and `err_flag` read 0 and `in_ready` reads 1.
- R2: The first six input beats accepted after reset produce no output word. Every accepted beat from the seventh on produces exactly one output word.
- R3: `in_codes[2k-1:2k-2]` holds the code of stage k, for k = 1 to 7, where stage 1 is the most significant. The word produced on the beat that carries stage 7's code is the sum over all k of code_k shifted left by (7 − k). Here code_k is the stage-k field from the beat accepted (7 − k) beats earlier.
- R4: The word appears on `out_data` with `out_valid` high right after the clock edge that accepts the beat completing it.
- R5: The flash stage (stage 7) uses all four codes 0 to 3. Stages 1 to 6 at code 2 together with stage 7 at code 3 give the full-scale word 255. All-zero codes give 0.
- R6: A code of 3 on any of stages 1 to 6 is summed as 2.
- R7: `err_flag` rises after an accepted beat that carries code 3 on any of stages 1 to 6, and only reset clears it. Code 3 on stage 7 does not set the flag, and neither does code 3 on a beat that is not accepted.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_data` and `out_valid` hold. Beats that are not accepted do not move any delay line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat |
| in_codes | input | 14 | Stage codes, stage k in bits [2k-1:2k-2] |
| out_valid | output | 1 | Corrected word present |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 8 | Corrected result |
| err_flag | output | 1 | Sticky illegal-code flag |

## Verification
A result is due right after the clock edge that accepts the beat carrying stage 7's code for that sample. The stage-1 part of that result was accepted six beats earlier. The bench therefore counts accepted beats and not cycles. It keeps a history of accepted beats and pushes an expected word only from the seventh accepted beat on. The monitor compares one word on each output handshake, sampling half a cycle after the edge. The directed parts check `out_valid` and `err_flag` at the falling edge that follows the accepting edge.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;
  localparam int CODE_W = 2;

  // Clamp a redundant 1.5-bit stage code: 3 is not legal, use 2.
  function automatic logic [CODE_W-1:0] legalize(input logic [CODE_W-1:0] c);
    return (c == 2'b11) ? 2'b10 : c;
  endfunction
endpackage

// File: rtl/adc_corr_delay.sv
module adc_corr_delay #(
  parameter int W     = 2,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign q = d;
    end else begin : g_line
      logic [W-1:0] tap [DEPTH];
      logic armed;

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) tap[i] <= '0;
          armed <= 1'b0;
        end else begin
          armed <= 1'b1;
          if (en) begin
            tap[0] <= d;
            for (int i = 1; i < DEPTH; i++) tap[i] <= tap[i-1];
          end
        end
      end
      assign q = tap[DEPTH-1];

      p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst || !armed)
        !en |=> $stable(q));
    end
  endgenerate
endmodule

// File: rtl/adc_corr_sum.sv
module adc_corr_sum #(
  parameter  int NSTAGE = 7,
  localparam int OUT_W  = NSTAGE + 1
) (
  input  logic [NSTAGE*2-1:0] codes,
  output logic [OUT_W-1:0]    word
);
  logic [OUT_W:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < NSTAGE; i++)
      acc = acc + ((OUT_W+1)'(codes[2*i +: 2]) << (NSTAGE - 1 - i));
    word = acc[OUT_W] ? {OUT_W{1'b1}} : acc[OUT_W-1:0];
  end
endmodule

// File: rtl/adc_corr_top.sv
module adc_corr_top #(
  parameter  int NSTAGE = 7,
  localparam int OUT_W  = NSTAGE + 1,
  localparam int FILL_W = $clog2(NSTAGE)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [NSTAGE*2-1:0] in_codes,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [OUT_W-1:0]    out_data,
  output logic                err_flag
);
  import adc_corr_pkg::*;

  logic                accept, bad, full, armed;
  logic [NSTAGE-1:0]   illegal;
  logic [NSTAGE*2-1:0] clean, aligned;
  logic [OUT_W-1:0]    word;
  logic [FILL_W-1:0]   fill;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  genvar g;
  generate
    for (g = 0; g < NSTAGE; g++) begin : g_lane
      if (g < NSTAGE - 1) begin : g_red
        assign illegal[g]      = (in_codes[2*g +: 2] == 2'b11);
        assign clean[2*g +: 2] = legalize(in_codes[2*g +: 2]);
      end else begin : g_flash
        assign illegal[g]      = 1'b0;
        assign clean[2*g +: 2] = in_codes[2*g +: 2];
      end
      adc_corr_delay #(.W(2), .DEPTH(NSTAGE - 1 - g)) u_dly (
        .clk(clk), .rst(rst), .en(accept),
        .d(clean[2*g +: 2]), .q(aligned[2*g +: 2]));
    end
  endgenerate

  assign bad  = |illegal;
  assign full = (fill == FILL_W'(NSTAGE - 1));

  adc_corr_sum #(.NSTAGE(NSTAGE)) u_sum (.codes(aligned), .word(word));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      err_flag  <= 1'b0;
      fill      <= '0;
      armed     <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (accept) begin
        out_valid <= full;
        out_data  <= word;
        if (!full) fill <= fill + 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (accept && bad) err_flag <= 1'b1;
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (rst || !armed)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  p_rise_r4: assert property (@(posedge clk) disable iff (rst || !armed)
    $rose(out_valid) |-> $past(accept));
  p_err_set_r7: assert property (@(posedge clk) disable iff (rst || !armed)
    accept && bad |=> err_flag);
  p_err_keep_r7: assert property (@(posedge clk) disable iff (rst || !armed)
    err_flag |=> err_flag);
endmodule

// File: tb/sim_adc_corr_top.sv
module sim_adc_corr_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 7;

  logic clk = 0, rst = 1, in_valid = 0, out_ready = 1;
  logic in_ready, out_valid, err_flag;
  logic [NS*2-1:0] in_codes = '0;
  logic [7:0] out_data;

  int tests = 0, fails = 0;
  bit rand_ready = 0;
  int expq[$];
  logic [NS*2-1:0] hist[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_corr_top u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_codes(in_codes), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .err_flag(err_flag));

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fixc(input int c, input int k);
    return (k < NS && c == 3) ? 2 : c;   // R6
  endfunction

  // R3: expected word from aligned history
  function automatic int model();
    int j = hist.size() - 1;
    int s = 0;
    for (int k = 1; k <= NS; k++) begin
      logic [NS*2-1:0] b = hist[j - (NS - k)];
      s += fixc(int'(b[2*k-1 -: 2]), k) << (NS - k);
    end
    return s > 255 ? 255 : s;
  endfunction

  task automatic drive_beat(input logic [NS*2-1:0] c);
    bit acc;
    do begin
      @(negedge clk); #1;
      in_valid = 1; in_codes = c;
      #1 acc = in_ready;
      @(posedge clk); #1;
      in_valid = 0;
    end while (!acc);
    hist.push_back(c);
    if (hist.size() >= NS) expq.push_back(model());
  endtask

  task automatic idle(input logic [NS*2-1:0] c);
    @(negedge clk); #1;
    in_valid = 0; in_codes = c;
    @(posedge clk); #1;
  endtask

  function automatic logic [NS*2-1:0] pack(input int r, input int f);
    logic [NS*2-1:0] v;
    for (int k = 1; k < NS; k++) v[2*k-1 -: 2] = 2'(r);
    v[2*NS-1 -: 2] = 2'(f);
    return v;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    expq.delete(); hist.delete();
  endtask

  // monitor / scoreboard
  initial forever begin
    @(negedge clk);
    out_ready = rand_ready ? ($urandom % 4 != 0) : 1'b1;
    #1;
    if (!rst && out_valid && out_ready) begin
      if (expq.size() == 0) check("R2 unexpected word", 1, 0);
      else check("R3 word", int'(out_data), expq.pop_front());
    end
  end

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [NS*2-1:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    #2;
    check("R1 out_valid", out_valid, 0);
    check("R1 err_flag", err_flag, 0);
    check("R1 in_ready", in_ready, 1);

    // R2/R4 latency in accepted beats; R5 full scale
    for (int i = 0; i < 6; i++) begin
      drive_beat(pack(2, 3));
      @(negedge clk); #2;
      check("R2 no word while filling", out_valid, 0);
    end
    drive_beat(pack(2, 3));
    @(negedge clk); #2;
    check("R4 word after 7th beat", out_valid, 1);
    check("R5 full scale", int'(out_data), 255);
    repeat (7) drive_beat(pack(0, 0));
    @(negedge clk); #2;
    check("R5 zero", int'(out_data), 0);
    for (int f = 0; f < 4; f++) drive_beat(pack(0, f));  // R5 flash codes

    // R7: non-accepted and flash 3 leave flag low
    idle(pack(3, 3));
    drive_beat(pack(0, 3));
    @(negedge clk); #2;
    check("R7 no flag from idle or flash", err_flag, 0);
    v = pack(1, 1); v[3:2] = 2'b11;
    drive_beat(v);                                   // R6 summed as 2
    @(negedge clk); #2;
    check("R7 flag set", err_flag, 1);
    repeat (8) drive_beat(pack(1, 2));
    check("R7 flag sticky", err_flag, 1);
    do_reset();
    #2;
    check("R1 flag cleared", err_flag, 0);
    check("R1 valid cleared", out_valid, 0);

    // R8 random traffic with back-pressure
    rand_ready = 1;
    for (int n = 0; n < 600; n++) begin
      v = NS*2'($urandom);
      for (int k = 1; k < NS; k++)
        if (v[2*k-1 -: 2] == 2'b11 && ($urandom % 8 != 0)) v[2*k-1 -: 2] = 2'b10;
      if ($urandom % 3 == 0) idle(NS*2'($urandom));
      drive_beat(v);
    end
    rand_ready = 0;
    repeat (20) @(negedge clk);
    check("R2 all words delivered", expq.size(), 0);
    finish_up();
  end
endmodule